// File: doc/BRIEF.md
# Store Queue with Load Disambiguation

This block keeps the stores that are still in flight in a circular queue, ordered as the program issued them. A store takes a slot when it is dispatched. Its address and its data are written into that slot later, each through its own write port, because they come from different producers and can arrive in either order.

A load reads the queue's tail position when it is dispatched and keeps that value. When the load's address is known, it presents the address together with the saved tail position. The block then searches all stores that sit ahead of the load and answers in the same cycle with one of four outcomes:

- the load must wait;
- the store's data is returned;
- the tag of the unit that will produce the store's data is returned;
- the load may read memory.

Stores leave from the head one at a time when the commit side retires them. A flush empties the queue in one cycle.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `head_valid` is 0, `alloc_ready` is 1 and `tail_pos` is 0.
- R2: An accepted allocation reports its slot as `alloc_idx`, equal to the low bits of `tail_pos`. `tail_pos` (slot bits plus one wrap bit) then advances by one, modulo 2*DEPTH. When DEPTH stores are held, `alloc_ready` is 0 and an allocation request changes nothing.
- R3: The address and the data of a slot are written through separate ports (`addr_wr` and `data_wr`, each with its own index), in either order. Each one becomes valid independently of the other.
- R4: A lookup looks only at stores that lie between the head and the snapshot `lk_pos`. Stores allocated at or after the snapshot position are never considered.
- R5: If any store ahead of the load has no valid address, `lk_result` is 3 (stall).
- R6: Otherwise, if the youngest store ahead of the load with an equal full address has valid data, `lk_result` is 1 and `lk_data` carries that data.
- R7: Otherwise, if that youngest matching store has no data yet, `lk_result` is 2 and `lk_tag` carries the producer tag given at its allocation. This holds even when an older matching store has data.
- R8: If no store ahead of the load matches and none lacks its address, `lk_result` is 0 (go to memory).
- R9: `head_addr` and `head_data` show the oldest store. `retire` removes it, in allocation order. A `retire` while the queue is empty is ignored.
- R10: `flush` empties the queue in one cycle: the tail position returns to 0 and all valid flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue |
| alloc_valid | input | 1 | Allocate a store slot |
| alloc_tag | input | TW | Producer tag of the store's data |
| alloc_ready | output | 1 | Queue has a free slot |
| alloc_idx | output | PW | Slot given to the allocation |
| tail_pos | output | PW+1 | Tail position with wrap bit, used as a load snapshot |
| addr_wr | input | 1 | Write a store address |
| addr_idx | input | PW | Slot for the address write |
| addr_val | input | AW | Store address |
| data_wr | input | 1 | Write store data |
| data_idx | input | PW | Slot for the data write |
| data_val | input | DW | Store data |
| lk_pos | input | PW+1 | The load's tail snapshot |
| lk_addr | input | AW | Load address |
| lk_result | output | 2 | 0 memory, 1 data, 2 tag, 3 stall |
| lk_data | output | DW | Forwarded data |
| lk_tag | output | TW | Forwarded producer tag |
| retire | input | 1 | Remove the head store |
| head_valid | output | 1 | Queue is not empty |
| head_addr | output | AW | Address of the oldest store |
| head_data | output | DW | Data of the oldest store |

## Verification
The hardest cases to reach are lookups whose window wraps around the end of the slot array, while several stores ahead of the load carry the same address and only some of them have data. The stimulus reaches these cases by first allocating and retiring a varying number of stores, which moves the head to every possible slot. It then fills a random mix of slots, with clashing addresses and data present or missing. Finally it replays a lookup for every snapshot position between the head and the tail, against every address.

// File: rtl/store_queue.sv
module store_queue #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TW = 4,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          alloc_valid,
  input  logic [TW-1:0] alloc_tag,
  output logic          alloc_ready,
  output logic [PW-1:0] alloc_idx,
  output logic [PW:0]   tail_pos,
  input  logic          addr_wr,
  input  logic [PW-1:0] addr_idx,
  input  logic [AW-1:0] addr_val,
  input  logic          data_wr,
  input  logic [PW-1:0] data_idx,
  input  logic [DW-1:0] data_val,
  input  logic [PW:0]   lk_pos,
  input  logic [AW-1:0] lk_addr,
  output logic [1:0]    lk_result,
  output logic [DW-1:0] lk_data,
  output logic [TW-1:0] lk_tag,
  input  logic          retire,
  output logic          head_valid,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data
);
  logic [AW-1:0] s_addr [DEPTH];
  logic [DW-1:0] s_data [DEPTH];
  logic [TW-1:0] s_tag  [DEPTH];
  logic [DEPTH-1:0] a_ok, d_ok;
  logic [PW:0] hd, tl, occ, diff, nold;
  logic push, pop, stall, hit;
  logic [PW-1:0] hslot;

  assign occ         = tl - hd;
  assign alloc_ready = (occ != (PW+1)'(DEPTH));
  assign head_valid  = (occ != '0);
  assign alloc_idx   = tl[PW-1:0];
  assign tail_pos    = tl;
  assign push        = alloc_valid && alloc_ready;
  assign pop         = retire && head_valid;
  assign head_addr   = s_addr[hd[PW-1:0]];
  assign head_data   = s_data[hd[PW-1:0]];

  assign diff = lk_pos - hd;
  assign nold = (diff <= occ) ? diff : '0;

  always_comb begin
    stall = 1'b0;
    hit   = 1'b0;
    hslot = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] sl;
      sl = hd[PW-1:0] + PW'(k);
      if ((PW+1)'(k) < nold) begin
        if (!a_ok[sl]) stall = 1'b1;
        else if (s_addr[sl] == lk_addr) begin
          hit   = 1'b1;
          hslot = sl;
        end
      end
    end
  end

  assign lk_result = stall ? 2'd3 : (hit ? (d_ok[hslot] ? 2'd1 : 2'd2) : 2'd0);
  assign lk_data   = s_data[hslot];
  assign lk_tag    = s_tag[hslot];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      hd   <= '0;
      tl   <= '0;
      a_ok <= '0;
      d_ok <= '0;
    end else begin
      if (push) tl <= tl + 1'b1;
      if (pop)  hd <= hd + 1'b1;
      if (addr_wr) a_ok[addr_idx] <= 1'b1;
      if (data_wr) d_ok[data_idx] <= 1'b1;
      if (push) begin
        a_ok[tl[PW-1:0]] <= 1'b0;
        d_ok[tl[PW-1:0]] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (addr_wr) s_addr[addr_idx] <= addr_val;
    if (data_wr) s_data[data_idx] <= data_val;
    if (push)    s_tag[tl[PW-1:0]] <= alloc_tag;
  end
endmodule

// File: rtl/store_queue_chk.sv
module store_queue_chk #(
  parameter int PW = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        alloc_valid,
  input logic        alloc_ready,
  input logic [PW:0] tail_pos,
  input logic        retire,
  input logic        head_valid,
  input logic [1:0]  lk_result
);
  p_refuse_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !alloc_ready && !flush |=> $stable(tail_pos));

  p_alloc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready && !flush |=> tail_pos == (PW+1)'($past(tail_pos) + 1'b1));

  p_full_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_ready |-> head_valid);

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !head_valid && alloc_ready && tail_pos == '0);

  p_empty_memory_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid |-> lk_result == 2'd0);

  p_retire_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid && retire && !alloc_valid && !flush |=> !head_valid);
endmodule

bind store_queue store_queue_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid),
  .alloc_ready(alloc_ready), .tail_pos(tail_pos), .retire(retire),
  .head_valid(head_valid), .lk_result(lk_result)
);

// File: tb/store_queue_test.sv
module store_queue_test;
  localparam int D = 8;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, flush, alloc_valid, addr_wr, data_wr, retire;
  logic [3:0] alloc_tag, tail_pos, lk_pos;
  logic [2:0] alloc_idx, addr_idx, data_idx;
  logic [31:0] addr_val, data_val, lk_addr, lk_data, head_addr, head_data;
  logic [1:0] lk_result;
  logic [3:0] lk_tag;
  logic alloc_ready, head_valid;

  store_queue uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid),
    .alloc_tag(alloc_tag), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .tail_pos(tail_pos), .addr_wr(addr_wr), .addr_idx(addr_idx), .addr_val(addr_val),
    .data_wr(data_wr), .data_idx(data_idx), .data_val(data_val), .lk_pos(lk_pos),
    .lk_addr(lk_addr), .lk_result(lk_result), .lk_data(lk_data), .lk_tag(lk_tag),
    .retire(retire), .head_valid(head_valid), .head_addr(head_addr), .head_data(head_data)
  );

  int total = 0, bad = 0;
  int sh = 0, st = 0;
  logic [31:0] m_a [D];
  logic [31:0] m_d [D];
  logic [3:0]  m_t [D];
  bit m_av [D];
  bit m_dv [D];
  int unsigned seed = 32'h1234_5678;

  function automatic int unsigned rnd();
    seed = seed * 1103515245 + 12345;
    return seed >> 8;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    alloc_valid = 0; addr_wr = 0; data_wr = 0; retire = 0; flush = 0; rst_n = 1;
  endtask

  task automatic do_flush();
    flush = 1;
    tick();
    sh = 0; st = 0;
    for (int i = 0; i < D; i++) begin m_av[i] = 0; m_dv[i] = 0; end
  endtask

  task automatic do_alloc(logic [3:0] tag);
    bit ok;
    ok = (st - sh) < D;
    chk("R2 ready", 32'(alloc_ready), 32'(ok));
    chk("R2 tail", 32'(tail_pos), 32'(st % 16));
    if (ok) chk("R2 idx", 32'(alloc_idx), 32'(st % D));
    alloc_valid = 1; alloc_tag = tag;
    tick();
    if (ok) begin
      m_av[st % D] = 0; m_dv[st % D] = 0; m_t[st % D] = tag;
      st++;
    end
  endtask

  task automatic fill_addr(int slot, logic [31:0] a);
    addr_wr = 1; addr_idx = 3'(slot); addr_val = a;
    tick();
    m_a[slot] = a; m_av[slot] = 1;
  endtask

  task automatic fill_data(int slot, logic [31:0] v);
    data_wr = 1; data_idx = 3'(slot); data_val = v;
    tick();
    m_d[slot] = v; m_dv[slot] = 1;
  endtask

  task automatic do_retire();
    chk("R9 head_valid", 32'(head_valid), 32'(st > sh));
    if (st > sh && m_av[sh % D] && m_dv[sh % D]) begin
      chk("R9 head_addr", head_addr, m_a[sh % D]);
      chk("R9 head_data", head_data, m_d[sh % D]);
    end
    retire = 1;
    tick();
    if (st > sh) sh++;
  endtask

  task automatic lookup(int snap, logic [31:0] a, string force_tag);
    int cnt, res, ys;
    string r;
    bit stl;
    cnt = snap - sh;
    stl = 0; ys = -1;
    for (int k = cnt - 1; k >= 0; k--) begin
      int s;
      s = (sh + k) % D;
      if (!m_av[s]) stl = 1;
      else if (ys < 0 && m_a[s] == a) ys = s;
    end
    res = stl ? 3 : (ys < 0 ? 0 : (m_dv[ys] ? 1 : 2));
    r = (res == 3) ? "R5" : (res == 1) ? "R6" : (res == 2) ? "R7" : "R8";
    if (force_tag != "") r = force_tag;
    lk_pos = 4'(snap % 16); lk_addr = a;
    #1;
    chk(r, 32'(lk_result), 32'(res));
    if (res == 1) chk({r, " data"}, lk_data, m_d[ys]);
    if (res == 2) chk({r, " tag"}, 32'(lk_tag), 32'(m_t[ys]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; flush = 0; alloc_valid = 0; addr_wr = 0; data_wr = 0; retire = 0;
    alloc_tag = 0; addr_idx = 0; data_idx = 0; addr_val = 0; data_val = 0;
    lk_pos = 0; lk_addr = 0;
    tick(); tick();
    // R1 reset state
    chk("R1 head_valid", 32'(head_valid), 0);
    chk("R1 alloc_ready", 32'(alloc_ready), 1);
    chk("R1 tail_pos", 32'(tail_pos), 0);

    // R2 full refusal
    for (int i = 0; i < D; i++) do_alloc(4'(i));
    chk("R2 full", 32'(alloc_ready), 0);
    do_alloc(4'hf);
    chk("R2 tail unchanged", 32'(tail_pos), 32'(8));

    // R10 flush with content
    fill_addr(0, 32'h40); fill_data(0, 32'h11);
    do_flush();
    chk("R10 head_valid", 32'(head_valid), 0);
    chk("R10 tail_pos", 32'(tail_pos), 0);
    chk("R10 alloc_ready", 32'(alloc_ready), 1);
    lookup(0, 32'h40, "R10");

    // R9 retire on empty ignored
    do_retire();
    chk("R9 empty tail", 32'(tail_pos), 0);
    chk("R9 empty head_valid", 32'(head_valid), 0);

    // R3 data before address, R4 snapshot excludes younger store
    do_alloc(4'h5);
    fill_data(0, 32'hcafe);
    lookup(1, 32'h80, "R3 stall");
    fill_addr(0, 32'h80);
    lookup(1, 32'h80, "R3");
    lookup(0, 32'h80, "R4");

    // R7 youngest without data beats older with data
    do_alloc(4'h9);
    fill_addr(1, 32'h80);
    lookup(2, 32'h80, "R7");
    lookup(1, 32'h80, "R6");
    do_retire(); do_retire();

    // sweep: every head offset, random fills, every snapshot, every address
    for (int off = 0; off < D; off++) begin
      for (int trial = 0; trial < 30; trial++) begin
        int n;
        do_flush();
        for (int i = 0; i < off; i++) begin
          do_alloc(4'(i));
          fill_addr(st - 1 < 0 ? 0 : (st - 1) % D, 32'h0);
          fill_data((st - 1) % D, 32'(i));
          do_retire();
        end
        n = int'(rnd() % 9);
        for (int i = 0; i < n; i++) begin
          int s;
          bit fa, fd, dfirst;
          logic [31:0] a, v;
          s = st % D;
          do_alloc(4'(rnd()));
          a = 32'h40 + 32'((rnd() % 3) * 4);
          v = 32'(rnd());
          fa = (rnd() % 8) != 0;
          fd = (rnd() % 2) != 0;
          dfirst = (rnd() % 2) != 0;
          if (dfirst && fd) fill_data(s, v);
          if (fa) fill_addr(s, a);
          if (!dfirst && fd) fill_data(s, v);
        end
        for (int s2 = sh; s2 <= st; s2++)
          for (int ai = 0; ai < 4; ai++)
            lookup(s2, 32'h40 + 32'(ai * 4), "");
        while (st > sh) do_retire();
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule